// File: doc/BRIEF.md
# Scintillator Coincidence Trigger Former

This block forms the triggers for one spectrometer arm from photomultiplier hit bits. There are two scintillator planes of six paddles each, and each paddle has a left tube and a right tube. A third, auxiliary plane has two tubes. A paddle registers a hit only when both of its tubes fire in the same cycle. The paddle hits of a plane are ORed into a single plane hit.

The block produces two triggers. The main trigger is a coincidence between the first plane and a second detector. In the default mode that second detector is the second plane. With `alt_mode` set, the auxiliary plane takes its place, and it counts only when both of its tubes fire. The efficiency trigger catches events that the main trigger missed: it is a loose combination of detectors, and any cycle that also forms a main trigger vetoes it. A parameter chooses which loose equation an instance uses. The plane hits are also brought out as monitor pins so that rate counters can be attached.

Every input is a synchronous hit pulse that lasts one cycle, and every output is a registered pulse that appears one cycle later. Hits cannot be held back or delayed, so the block has no valid/ready handshake and no back-pressure: each clock edge consumes one hit pattern and produces one output pattern.

Top module: `coinc_trigger_former`

## Requirements
- R1: While `rst_n` is low, all five outputs are 0 on the clock edge that follows.
- R2: A paddle hits only when its left bit and its right bit are both 1 in the same cycle. `p1_or` and `p2_or` are the OR of the six paddle hits of their plane. A paddle with only one tube firing never sets the plane output.
- R3: With `alt_mode` = 0, `main_trig` = `p1_or` AND `p2_or`.
- R4: `aux_and` is 1 exactly when `aux_a` and `aux_b` are both 1.
- R5: With `alt_mode` = 1, `main_trig` = `p1_or` AND `aux_and`, and the second plane has no effect on `main_trig`.
- R6: With `EFF_KIND` = `EFF_MAJORITY` (0), `eff_trig` = ((AUX AND P1) OR (AUX AND P2)) AND NOT MAIN. AUX is the two-tube AND of the auxiliary plane, P1 and P2 are the plane ORs, and MAIN is the main trigger of the same cycle.
- R7: With `EFF_KIND` = `EFF_WIDE` (1), `eff_trig` = (P2 AND (P1 OR `aux_a` OR `aux_b`)) AND NOT MAIN. Here each auxiliary tube counts on its own.
- R8: `eff_trig` and `main_trig` are never 1 in the same cycle.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. A hit pattern that lasts one cycle therefore gives an output pulse that lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_mode | input | 1 | 0: main = plane1 AND plane2; 1: main = plane1 AND auxiliary plane |
| p1_left | input | 6 | Left-tube hits, first plane, one bit per paddle |
| p1_right | input | 6 | Right-tube hits, first plane |
| p2_left | input | 6 | Left-tube hits, second plane |
| p2_right | input | 6 | Right-tube hits, second plane |
| aux_a | input | 1 | Auxiliary plane, tube A hit |
| aux_b | input | 1 | Auxiliary plane, tube B hit |
| main_trig | output | 1 | Registered main trigger |
| eff_trig | output | 1 | Registered efficiency trigger |
| p1_or | output | 1 | Registered first-plane hit (monitor) |
| p2_or | output | 1 | Registered second-plane hit (monitor) |
| aux_and | output | 1 | Registered auxiliary-plane hit (monitor) |

## Verification
Some properties are checked on every cycle by assertions:
- the veto that keeps the main and efficiency triggers apart;
- the one-cycle path from a full paddle hit, or from both auxiliary tubes, to its monitor output;
- that a main trigger always comes with a first-plane hit;
- that in the alternative mode a first-plane hit together with both auxiliary tubes always gives a main trigger.

Other behaviours only the bench scenarios can show:
- that a paddle with just one tube firing stays silent;
- that the second plane has no effect in the alternative mode;
- that each efficiency equation holds over all combinations.

To cover these, the bench sweeps every single-paddle and single-tube pattern in both modes and against each auxiliary combination, then runs random sparse hit patterns on one instance of each efficiency kind.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Selects the loose equation that forms the efficiency trigger.
  typedef enum logic {
    EFF_MAJORITY = 1'b0,  // aux AND (p1 OR p2)
    EFF_WIDE     = 1'b1   // p2 AND (p1 OR either aux tube)
  } eff_kind_e;

  // One registered output word.
  typedef struct packed {
    logic main_trig;
    logic eff_trig;
    logic p1_or;
    logic p2_or;
    logic aux_and;
  } trig_word_t;
endpackage

// File: rtl/paddle_plane.sv
module paddle_plane #(
  parameter int PADDLES = 6
) (
  input  logic [PADDLES-1:0] tube_l,
  input  logic [PADDLES-1:0] tube_r,
  output logic               plane_hit
);
  logic [PADDLES-1:0] paddle_hit;

  // A paddle counts only when both of its ends see light.
  for (genvar g = 0; g < PADDLES; g++) begin : g_paddle
    assign paddle_hit[g] = tube_l[g] & tube_r[g];
  end

  assign plane_hit = |paddle_hit;
endmodule

// File: rtl/trig_logic.sv
module trig_logic
  import trig_pkg::*;
#(
  parameter eff_kind_e EFF_KIND = EFF_MAJORITY
) (
  input  logic alt_mode,
  input  logic p1,
  input  logic p2,
  input  logic aux_a,
  input  logic aux_b,
  output logic aux_both,
  output logic main_hit,
  output logic eff_hit
);
  logic partner;

  assign aux_both = aux_a & aux_b;
  // The coincidence partner of plane 1 depends on the mode.
  assign partner  = alt_mode ? aux_both : p2;
  assign main_hit = p1 & partner;

  if (EFF_KIND == EFF_MAJORITY) begin : g_eff_maj
    assign eff_hit = aux_both & (p1 | p2) & ~main_hit;
  end else begin : g_eff_wide
    assign eff_hit = p2 & (p1 | aux_a | aux_b) & ~main_hit;
  end
endmodule

// File: rtl/coinc_trigger_former.sv
module coinc_trigger_former
  import trig_pkg::*;
#(
  parameter int        PADDLES  = 6,
  parameter eff_kind_e EFF_KIND = EFF_MAJORITY
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alt_mode,
  input  logic [PADDLES-1:0] p1_left,
  input  logic [PADDLES-1:0] p1_right,
  input  logic [PADDLES-1:0] p2_left,
  input  logic [PADDLES-1:0] p2_right,
  input  logic               aux_a,
  input  logic               aux_b,
  output logic               main_trig,
  output logic               eff_trig,
  output logic               p1_or,
  output logic               p2_or,
  output logic               aux_and
);
  logic       p1_hit, p2_hit, aux_hit, main_hit, eff_hit;
  trig_word_t nxt_q, out_q;

  paddle_plane #(.PADDLES(PADDLES)) u_plane1 (
    .tube_l(p1_left), .tube_r(p1_right), .plane_hit(p1_hit)
  );

  paddle_plane #(.PADDLES(PADDLES)) u_plane2 (
    .tube_l(p2_left), .tube_r(p2_right), .plane_hit(p2_hit)
  );

  trig_logic #(.EFF_KIND(EFF_KIND)) u_logic (
    .alt_mode(alt_mode), .p1(p1_hit), .p2(p2_hit),
    .aux_a(aux_a), .aux_b(aux_b), .aux_both(aux_hit),
    .main_hit(main_hit), .eff_hit(eff_hit)
  );

  always_comb begin
    nxt_q.main_trig = main_hit;
    nxt_q.eff_trig  = eff_hit;
    nxt_q.p1_or     = p1_hit;
    nxt_q.p2_or     = p2_hit;
    nxt_q.aux_and   = aux_hit;
  end

  // Output stage: one cycle of latency, synchronous reset.
  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= nxt_q;
  end

  assign main_trig = out_q.main_trig;
  assign eff_trig  = out_q.eff_trig;
  assign p1_or     = out_q.p1_or;
  assign p2_or     = out_q.p2_or;
  assign aux_and   = out_q.aux_and;

  // R1: reset clears every output on the following edge
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!main_trig && !eff_trig && !p1_or && !p2_or && !aux_and));

  // R2: a full paddle hit on plane 1 shows on the monitor one cycle later
  p_plane1_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(p1_left & p1_right)) |=> p1_or);

  // R2: the same for plane 2
  p_plane2_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(p2_left & p2_right)) |=> p2_or);

  // R4: both auxiliary tubes lead to the auxiliary monitor
  p_aux_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_a && aux_b) |=> aux_and);

  // R3: a main trigger always comes with a first-plane hit
  p_main_needs_p1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    main_trig |-> p1_or);

  // R5: in the alternative mode, plane 1 plus both aux tubes fires main
  p_alt_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode && (|(p1_left & p1_right)) && aux_a && aux_b) |=> main_trig);

  // R8: the veto keeps the two triggers apart
  p_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_trig && eff_trig));
endmodule

// File: tb/coinc_trigger_former_test.sv
`timescale 1ns/1ps
module coinc_trigger_former_test;
  import trig_pkg::*;

  localparam int N = 6;

  typedef struct packed {
    logic main_t;
    logic eff_a;
    logic eff_b;
    logic p1;
    logic p2;
    logic aux;
    logic alt;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         alt_mode = 1'b0;
  logic [N-1:0] p1_left = '0, p1_right = '0, p2_left = '0, p2_right = '0;
  logic         aux_a = 1'b0, aux_b = 1'b0;
  logic         main_a, eff_a, p1o_a, p2o_a, auxo_a;
  logic         main_b, eff_b, p1o_b, p2o_b, auxo_b;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   mon_on  = 1'b0;
  bit   done    = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  coinc_trigger_former #(.PADDLES(N), .EFF_KIND(EFF_MAJORITY)) uut (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
    .p1_left(p1_left), .p1_right(p1_right),
    .p2_left(p2_left), .p2_right(p2_right),
    .aux_a(aux_a), .aux_b(aux_b),
    .main_trig(main_a), .eff_trig(eff_a),
    .p1_or(p1o_a), .p2_or(p2o_a), .aux_and(auxo_a)
  );

  coinc_trigger_former #(.PADDLES(N), .EFF_KIND(EFF_WIDE)) uut_b (
    .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
    .p1_left(p1_left), .p1_right(p1_right),
    .p2_left(p2_left), .p2_right(p2_right),
    .aux_a(aux_a), .aux_b(aux_b),
    .main_trig(main_b), .eff_trig(eff_b),
    .p1_or(p1o_b), .p2_or(p2o_b), .aux_and(auxo_b)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Reference model written from the requirements.
  function automatic exp_t ref_model(input logic alt,
      input logic [N-1:0] l1, input logic [N-1:0] r1,
      input logic [N-1:0] l2, input logic [N-1:0] r2,
      input logic a, input logic b);
    exp_t e;
    logic s1, s2, ax;
    s1 = 1'b0;
    s2 = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (l1[i] && r1[i]) s1 = 1'b1;
      if (l2[i] && r2[i]) s2 = 1'b1;
    end
    ax       = a && b;
    e.alt    = alt;
    e.p1     = s1;
    e.p2     = s2;
    e.aux    = ax;
    e.main_t = alt ? (s1 && ax) : (s1 && s2);
    e.eff_a  = ((ax && s1) || (ax && s2)) && !e.main_t;
    e.eff_b  = (s2 && (s1 || a || b)) && !e.main_t;
    return e;
  endfunction

  // Driver: apply one pattern at the falling edge and queue its expectation.
  task automatic drive(input logic alt,
      input logic [N-1:0] l1, input logic [N-1:0] r1,
      input logic [N-1:0] l2, input logic [N-1:0] r2,
      input logic a, input logic b);
    @(negedge clk);
    alt_mode = alt;
    p1_left  = l1;
    p1_right = r1;
    p2_left  = l2;
    p2_right = r2;
    aux_a    = a;
    aux_b    = b;
    sb_q.push_back(ref_model(alt, l1, r1, l2, r2, a, b));
  endtask

  // Monitor: one cycle after each edge, compare against the oldest item.
  always @(posedge clk) begin
    if (mon_on && sb_q.size() > 0) begin
      exp_t e;
      #1;
      e = sb_q.pop_front();
      check(e.alt ? "R5 main" : "R3 main", main_a, e.main_t);
      check("R9 latency/R3 main (wide inst)", main_b, e.main_t);
      check("R2 p1_or", p1o_a, e.p1);
      check("R2 p2_or", p2o_a, e.p2);
      check("R4 aux_and", auxo_a, e.aux);
      check(e.main_t ? "R8 veto (majority)" : "R6 eff majority", eff_a, e.eff_a);
      check(e.main_t ? "R8 veto (wide)" : "R7 eff wide", eff_b, e.eff_b);
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] one;
    // R1: reset with live inputs still clears the outputs
    p1_left = '1; p1_right = '1; p2_left = '1; p2_right = '1;
    aux_a = 1'b1; aux_b = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 main", main_a, 1'b0);
    check("R1 eff", eff_a, 1'b0);
    check("R1 p1_or", p1o_a, 1'b0);
    check("R1 p2_or", p2o_a, 1'b0);
    check("R1 aux_and", auxo_a, 1'b0);
    check("R1 eff wide", eff_b, 1'b0);
    p1_left = '0; p1_right = '0; p2_left = '0; p2_right = '0;
    aux_a = 1'b0; aux_b = 1'b0;
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R2/R3/R5: exhaustive single-paddle, single-side patterns in both modes
    for (int m = 0; m < 2; m++) begin
      for (int ax = 0; ax < 4; ax++) begin
        for (int p = 0; p < N; p++) begin
          one = '0;
          one[p] = 1'b1;
          // left only, right only, both ends: plane 1 alone
          drive(m[0], one, '0, '0, '0, ax[0], ax[1]);
          drive(m[0], '0, one, '0, '0, ax[0], ax[1]);
          drive(m[0], one, one, '0, '0, ax[0], ax[1]);
          // plane 2 alone
          drive(m[0], '0, '0, one, '0, ax[0], ax[1]);
          drive(m[0], '0, '0, one, one, ax[0], ax[1]);
          // a full paddle in plane 2 with a half paddle in plane 1
          drive(m[0], one, '0, one, one, ax[0], ax[1]);
          // full paddles in both planes, different positions
          drive(m[0], one, one, {one[0], one[N-1:1]}, {one[0], one[N-1:1]},
                ax[0], ax[1]);
          // left of one paddle, right of another: no hit
          drive(m[0], one, {one[N-2:0], one[N-1]}, one, {one[N-2:0], one[N-1]},
                ax[0], ax[1]);
        end
      end
    end

    // R9: a single pulse followed by an idle cycle
    drive(1'b0, 6'b000001, 6'b000001, 6'b100000, 6'b100000, 1'b0, 1'b0);
    drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0);

    // Random sparse hit patterns, both modes
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] l1, r1, l2, r2;
      l1 = N'($urandom) & N'($urandom);
      r1 = N'($urandom) | l1;
      l2 = N'($urandom) & N'($urandom);
      r2 = N'($urandom) & N'($urandom);
      drive(1'($urandom), l1, r1, l2, r2, 1'($urandom), 1'($urandom));
    end

    drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule